// File: doc/BRIEF.md
# Peripheral Interrupt Sequencer

This block sits beside a small CPU core that has a single interrupt entry point. Every peripheral source has an event line. A pulse on that line sets a request flag, and the flag stays set until software clears it. Each source also has its own enable bit. Two further switches sit above those bits: a master enable and a group enable. A request reaches the core only when all three levels allow it. Software finds out which source fired by reading the flags. The block does not rank sources by priority.

The core checks the request line at each instruction boundary. When it accepts an interrupt, the block sends the next fetch to one fixed entry address and stores the interrupted program counter on a small return stack. It also drops the master enable, so the handler cannot be re-entered. A return strobe takes the saved counter off the stack, sends fetch back to it, and turns the master enable on again. If the stack is pushed past its depth, it wraps round and sets a sticky overflow status bit.

Software reaches the state through a register window of four 8-bit addresses.

Top module: `irq_sequencer`

## Requirements
- R1: `irq_req_o` is high, combinationally, exactly when the master enable, the group enable and at least one flag whose source enable is set are all present.
- R2: A one-cycle pulse on `evt_i[i]` sets flag i, and the flag holds until it is cleared. Writing a 1 to bit i at address 2 clears flag i. Writing a 0 to that bit leaves it unchanged.
- R3: The registers are laid out as follows. Address 0 holds the master enable at bit 0 and the group enable at bit 1, both read/write. Bit 7 of address 0 is the overflow status: it is read-only, and writing a 1 to it clears it. Address 1 holds the per-source enables in bits [N-1:0]. Address 2 holds the flags. Unused bits and address 3 read as 0. Everything resets to 0.
- R4: In a cycle where `take_i` is high and `irq_req_o` is high, `redirect_o` is 1 and `redirect_pc_o` is 0x0004 in that same cycle. When `take_i` is high and no request is present, there is no redirect and no state changes.
- R5: Accepting an interrupt pushes `cur_pc_i` and clears the master enable from the next cycle on. The group enable is left unchanged. This clear wins over a software write to address 0 in the same cycle.
- R6: A pulse on `ret_i` gives `redirect_o` = 1 with `redirect_pc_o` equal to the most recently pushed value that has not been popped, in last-in-first-out order. It also sets the master enable from the next cycle on.
- R7: The return stack holds 8 entries. A ninth push without an intervening pop overwrites the oldest entry and sets the overflow status bit, which stays set until software clears it. The first pop after that returns the ninth value.
- R8: An event on a source in the same cycle as a software clear of that source leaves the flag set.
- R9: When `ret_i` and `take_i` are high in the same cycle, only the return is served. Nothing is pushed, and `redirect_pc_o` is the stack top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | SRC_N | Peripheral event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| irq_req_o | output | 1 | Interrupt request to the core |
| take_i | input | 1 | Core is at an instruction boundary and takes a pending request |
| cur_pc_i | input | PC_W | Program counter to save on entry |
| ret_i | input | 1 | Return-from-interrupt strobe |
| redirect_o | output | 1 | Force the next fetch to `redirect_pc_o` |
| redirect_pc_o | output | PC_W | Entry address or restored return address |

## Verification
The request gate is tested one enable level at a time. The master enable is set alone, then joined by the group enable, and then the source enables are moved between a pending source and an idle one, so that each level is shown to block the request on its own. Flags are tested with an isolated pulse, with a hold over idle cycles, with a plain clear, and with a clear that coincides with an event. Together these separate a true latch from a level follower and show which side wins a same-cycle collision. The stack is tested in three ways: two nested entries whose returns must come back reversed, nine entries in a row that must wrap and leave the overflow bit set, and a return that coincides with a take, which must leave the stack contents as they were.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;
    localparam int REG_W      = 8;
    localparam int ADDR_W     = 2;
    localparam int GIE_BIT    = 0;
    localparam int GRP_BIT    = 1;
    localparam int OVF_BIT    = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_IEN  = 2'd1,
        RA_FLAG = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic ovf;
        logic grp;
        logic gie;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] v;
        v          = '0;
        v[GIE_BIT] = c.gie;
        v[GRP_BIT] = c.grp;
        v[OVF_BIT] = c.ovf;
        return v;
    endfunction
endpackage

// File: rtl/irq_src_bank.sv
`timescale 1ns/1ps
module irq_src_bank #(
    parameter int SRC_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] evt,
    input  logic             ien_wr,
    input  logic             flag_wr,
    input  logic [SRC_N-1:0] wdata,
    output logic [SRC_N-1:0] ien_q,
    output logic [SRC_N-1:0] flag_q,
    output logic             pending
);
    always_ff @(posedge clk) begin
        if (rst)         ien_q <= '0;
        else if (ien_wr) ien_q <= wdata;
    end

    for (genvar i = 0; i < SRC_N; i++) begin : g_flag
        logic clr;
        assign clr = flag_wr & wdata[i];
        always_ff @(posedge clk) begin
            if (rst)         flag_q[i] <= 1'b0;
            else if (evt[i]) flag_q[i] <= 1'b1;
            else if (clr)    flag_q[i] <= 1'b0;
        end
    end

    assign pending = |(flag_q & ien_q);
endmodule

// File: rtl/irq_ret_stack.sv
`timescale 1ns/1ps
module irq_ret_stack #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_pc,
    output logic [PC_W-1:0] top_pc,
    output logic            ovf_set
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [PC_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] wp, wp_next, wp_prev;
    logic [CNT_W-1:0] cnt;

    assign wp_next = (wp == LAST) ? '0 : wp + 1'b1;
    assign wp_prev = (wp == '0) ? LAST : wp - 1'b1;
    assign top_pc  = mem[wp_prev];
    assign ovf_set = push && (cnt == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            cnt <= '0;
        end else if (pop) begin
            wp  <= wp_prev;
            cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
        end else if (push) begin
            wp  <= wp_next;
            cnt <= (cnt == FULL) ? FULL : cnt + 1'b1;
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[k] <= '0;
            else if (push && !pop && wp == PTR_W'(k))
                mem[k] <= push_pc;
        end
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs
    import irq_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  logic  wd_gie,
    input  logic  wd_grp,
    input  logic  wd_ovf_clr,
    input  logic  hw_clr_gie,
    input  logic  hw_set_gie,
    input  logic  ovf_set,
    output ctrl_t ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (hw_clr_gie)      ctrl_q.gie <= 1'b0;
            else if (hw_set_gie) ctrl_q.gie <= 1'b1;
            else if (wr)         ctrl_q.gie <= wd_gie;

            if (wr) ctrl_q.grp <= wd_grp;

            if (ovf_set)                ctrl_q.ovf <= 1'b1;
            else if (wr && wd_ovf_clr)  ctrl_q.ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_sequencer.sv
`timescale 1ns/1ps
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int              SRC_N  = 4,
    parameter int              PC_W   = 16,
    parameter int              DEPTH  = 8,
    parameter logic [PC_W-1:0] VECTOR = 16'h0004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  evt_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_req_o,
    input  logic              take_i,
    input  logic [PC_W-1:0]   cur_pc_i,
    input  logic              ret_i,
    output logic              redirect_o,
    output logic [PC_W-1:0]   redirect_pc_o
);
    reg_addr_e        ra;
    logic             wr_ctrl, wr_ien, wr_flag;
    logic [SRC_N-1:0] ien_q, flag_q;
    logic             pending, accept, ovf_set;
    logic [PC_W-1:0]  top_pc;
    ctrl_t            ctrl_q;
    logic             gie_q, grp_q, ovf_q;
    wire              unused_wdata = ^reg_wdata_i;

    assign ra      = reg_addr_e'(reg_addr_i);
    assign wr_ctrl = reg_wr_i && (ra == RA_CTRL);
    assign wr_ien  = reg_wr_i && (ra == RA_IEN);
    assign wr_flag = reg_wr_i && (ra == RA_FLAG);

    irq_src_bank #(.SRC_N(SRC_N)) u_src (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_i),
        .ien_wr  (wr_ien),
        .flag_wr (wr_flag),
        .wdata   (reg_wdata_i[SRC_N-1:0]),
        .ien_q   (ien_q),
        .flag_q  (flag_q),
        .pending (pending)
    );

    assign gie_q     = ctrl_q.gie;
    assign grp_q     = ctrl_q.grp;
    assign ovf_q     = ctrl_q.ovf;
    assign irq_req_o = gie_q && grp_q && pending;
    assign accept    = take_i && irq_req_o && !ret_i;

    irq_ret_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) u_stk (
        .clk     (clk),
        .rst     (rst),
        .push    (accept),
        .pop     (ret_i),
        .push_pc (cur_pc_i),
        .top_pc  (top_pc),
        .ovf_set (ovf_set)
    );

    irq_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_ctrl),
        .wd_gie     (reg_wdata_i[GIE_BIT]),
        .wd_grp     (reg_wdata_i[GRP_BIT]),
        .wd_ovf_clr (reg_wdata_i[OVF_BIT]),
        .hw_clr_gie (accept),
        .hw_set_gie (ret_i),
        .ovf_set    (ovf_set),
        .ctrl_q     (ctrl_q)
    );

    assign redirect_o    = accept || ret_i;
    assign redirect_pc_o = ret_i ? top_pc : VECTOR;

    always_comb begin
        reg_rdata_o = '0;
        unique case (ra)
            RA_CTRL: reg_rdata_o = pack_ctrl(ctrl_q);
            RA_IEN:  reg_rdata_o[SRC_N-1:0] = ien_q;
            RA_FLAG: reg_rdata_o[SRC_N-1:0] = flag_q;
            RA_NONE: reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_sequencer_chk.sv
`timescale 1ns/1ps
module irq_sequencer_chk #(
    parameter int              SRC_N  = 4,
    parameter int              PC_W   = 16,
    parameter logic [PC_W-1:0] VECTOR = 16'h0004
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_req,
    input logic             take,
    input logic             ret,
    input logic             redirect,
    input logic [PC_W-1:0]  redirect_pc,
    input logic             gie,
    input logic             grp,
    input logic             ovf,
    input logic [SRC_N-1:0] flags,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_wdata
);
    // R1: a request needs both enables and some flag
    a_r1_req_gated: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (gie && grp && (flags != '0)));

    // R2: flags only drop after a clear write
    a_r2_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == 2'd2) |=> ((flags & $past(flags)) == $past(flags)));

    // R4: accepted entry redirects to the fixed vector
    a_r4_vector: assert property (@(posedge clk) disable iff (rst)
        (take && irq_req && !ret) |-> (redirect && redirect_pc == VECTOR));

    // R4: no redirect without entry or return
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!ret && !(take && irq_req)) |-> !redirect);

    // R5: entry clears the master enable
    a_r5_gie_cleared: assert property (@(posedge clk) disable iff (rst)
        (take && irq_req && !ret) |=> !gie);

    // R6: return restores the master enable
    a_r6_gie_restored: assert property (@(posedge clk) disable iff (rst)
        ret |=> gie);

    // R7: overflow status is sticky
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(reg_wr && reg_addr == 2'd0 && reg_wdata[7])) |=> ovf);
endmodule

bind irq_sequencer irq_sequencer_chk #(
    .SRC_N (SRC_N),
    .PC_W  (PC_W),
    .VECTOR(VECTOR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_req     (irq_req_o),
    .take        (take_i),
    .ret         (ret_i),
    .redirect    (redirect_o),
    .redirect_pc (redirect_pc_o),
    .gie         (gie_q),
    .grp         (grp_q),
    .ovf         (ovf_q),
    .flags       (flag_q),
    .reg_wr      (reg_wr_i),
    .reg_addr    (reg_addr_i),
    .reg_wdata   (reg_wdata_i)
);

// File: tb/tb_irq_sequencer.sv
`timescale 1ns/1ps
module tb_irq_sequencer;
    localparam int SRC_N = 4;
    localparam int PC_W  = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [SRC_N-1:0] evt_i = '0;
    logic             reg_wr_i = 1'b0;
    logic [1:0]       reg_addr_i = '0;
    logic [7:0]       reg_wdata_i = '0;
    logic [7:0]       reg_rdata_o;
    logic             irq_req_o;
    logic             take_i = 1'b0;
    logic [PC_W-1:0]  cur_pc_i = '0;
    logic             ret_i = 1'b0;
    logic             redirect_o;
    logic [PC_W-1:0]  redirect_pc_o;

    irq_sequencer dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_req_o(irq_req_o), .take_i(take_i),
        .cur_pc_i(cur_pc_i), .ret_i(ret_i), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o)
    );

    always #2.5 clk = ~clk;

    localparam int S_REQ = 0, S_RDIR = 1, S_RPC = 2, S_RD = 3;
    typedef struct {
        string req;
        int    sel;
        int    val;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    function automatic int observe(int sel);
        case (sel)
            S_REQ:   return int'(irq_req_o);
            S_RDIR:  return int'(redirect_o);
            S_RPC:   return int'(redirect_pc_o);
            default: return int'(reg_rdata_o);
        endcase
    endfunction

    // monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                int    act;
                it  = q.pop_front();
                act = observe(it.sel);
                n_cmp++;
                if (act !== it.val) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h",
                             it.req, it.sel, act, it.val);
                end
            end
        end
    end

    task automatic expect_v(string r, int sel, int v);
        item_t it;
        it.req = r; it.sel = sel; it.val = v;
        q.push_back(it);
    endtask

    task automatic cyc();
        @(posedge clk); #1;
        evt_i = '0; reg_wr_i = 1'b0; take_i = 1'b0; ret_i = 1'b0;
    endtask

    task automatic wr(int a, int d);
        cyc(); reg_wr_i = 1'b1; reg_addr_i = 2'(a); reg_wdata_i = 8'(d);
    endtask

    task automatic rd(string r, int a, int v);
        cyc(); reg_addr_i = 2'(a); expect_v(r, S_RD, v);
    endtask

    task automatic req_is(string r, int v);
        cyc(); expect_v(r, S_REQ, v);
    endtask

    task automatic enter(string r, int pc, int exp_dir);
        cyc(); take_i = 1'b1; cur_pc_i = 16'(pc);
        expect_v(r, S_RDIR, exp_dir);
        if (exp_dir != 0) expect_v(r, S_RPC, 16'h0004);
    endtask

    task automatic leave(string r, int exp_pc);
        cyc(); ret_i = 1'b1;
        expect_v(r, S_RDIR, 1);
        expect_v(r, S_RPC, exp_pc);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R3 reset state
        rd("R3 reset ctrl", 0, 0);
        rd("R3 reset ien", 1, 0);
        rd("R3 reset flags", 2, 0);
        rd("R3 addr3 zero", 3, 0);
        req_is("R1 reset no req", 0);

        // R2 latch and hold
        cyc(); evt_i = 4'b0010;
        rd("R2 flag latched", 2, 8'h02);
        cyc(); cyc(); cyc();
        rd("R2 flag held", 2, 8'h02);

        // R1 enable levels
        wr(1, 8'h02);
        req_is("R1 gie off", 0);
        wr(0, 8'h01);
        req_is("R1 group off", 0);
        wr(0, 8'h03);
        req_is("R1 all enabled", 1);
        rd("R3 ctrl readback", 0, 8'h03);
        rd("R3 ien readback", 1, 8'h02);
        cyc(); evt_i = 4'b0001;
        rd("R2 second flag", 2, 8'h03);
        wr(1, 8'h04);
        req_is("R1 idle source enabled", 0);
        wr(1, 8'h01);
        req_is("R1 other pending source", 1);
        wr(1, 8'h02);

        // R8 collision, R2 clear
        wr(2, 8'h01); evt_i = 4'b0001;
        rd("R8 event beats clear", 2, 8'h03);
        wr(2, 8'h01);
        rd("R2 w1c clear", 2, 8'h02);
        wr(2, 8'h00);
        rd("R2 write zero keeps", 2, 8'h02);

        // R4/R5 entry
        enter("R4 entry vector", 16'h1234, 1);
        rd("R5 gie cleared grp kept", 0, 8'h02);
        req_is("R5 req blocked", 0);
        enter("R4 take without req", 16'h5555, 0);
        wr(0, 8'h03);
        enter("R5 entry vs write", 16'h2222, 1);
        reg_wr_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h03;
        rd("R5 entry wins over write", 0, 8'h02);

        // R6 returns, LIFO
        leave("R6 pop newest", 16'h2222);
        rd("R6 gie restored", 0, 8'h03);
        leave("R6 pop oldest", 16'h1234);

        // R7 overflow
        for (int k = 0; k < 9; k++) begin
            enter("R7 push", 16'h0100 + k, 1);
            if (k == 7) rd("R7 no overflow at depth", 0, 8'h02);
            wr(0, 8'h03);
        end
        rd("R7 overflow set", 0, 8'h83);
        leave("R7 wrapped top", 16'h0108);
        rd("R7 overflow sticky", 0, 8'h83);
        wr(0, 8'h83);
        rd("R3 overflow w1c", 0, 8'h03);

        // R9 return and take together
        cyc(); ret_i = 1'b1; take_i = 1'b1; cur_pc_i = 16'h7777;
        expect_v("R9 return served", S_RDIR, 1);
        expect_v("R9 return pc", S_RPC, 16'h0107);
        rd("R9 gie set", 0, 8'h03);
        leave("R9 nothing pushed", 16'h0106);

        cyc(); cyc();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule